// File: doc/BRIEF.md
# Serial Memory Write Guard with Locked Configuration Register

This block decides which writes reach a 256-byte serial memory and a pair of resistor wiper settings. It sits behind a two-wire slave front end that has already turned line activity into decoded pulses: start and stop events, a device-address byte with its read/write bit, the address byte, and each data byte. The block follows every transaction in a single state machine. It acknowledges or refuses each data byte and passes allowed bytes on as write strobes. It also holds a small configuration register whose two lock bits pick how much of the memory is read-only.

The lock bits can only be changed by a fixed series of three write transactions. The first arms a write-arm latch. The second also arms a register-arm latch. The third carries the new lock value and starts a nonvolatile commit. A commit keeps the block busy for a parameterised number of clock cycles. Accepted memory or wiper writes also start one when their transaction stops. While the block is busy it ignores every new command. A hardware write-protect input blocks all memory and wiper writes whatever the lock bits are, and any nonzero lock value also freezes both wipers.

Device addresses (7 bits): memory `1010000`, wipers `1010001`, configuration register `1010010` with address byte `FFh`.

Top module: `wguard_top`

States: `ST_IDLE` (waiting for a device byte), `ST_REG_ADDR`, `ST_REG_DATA`, `ST_REG_HOLD` (one register byte held until stop), `ST_MEM_ADDR`, `ST_MEM_DATA`, `ST_WPR_ADDR`, `ST_WPR_DATA`, `ST_SKIP` (the transaction is ignored or aborted until the next start or stop).

Transitions:
- A stop event sends any state to `ST_IDLE`. A start event does the same.
- From `ST_IDLE`, a device byte goes to `ST_SKIP` when the block is busy, when the byte is a read, or when the address is unknown. Otherwise it goes to the matching `*_ADDR` state.
- `ST_REG_ADDR` goes to `ST_REG_DATA` on `FFh` and to `ST_SKIP` on any other address.
- `ST_REG_DATA` goes to `ST_REG_HOLD` on a legal byte and to `ST_SKIP` when a reserved bit is set.
- `ST_REG_HOLD` goes to `ST_SKIP` when a second byte arrives.
- `ST_MEM_ADDR` and `ST_WPR_ADDR` go to their data states. A wiper index of 2 or more goes to `ST_SKIP`.
- `ST_MEM_DATA` and `ST_WPR_DATA` stay put on allowed bytes and go to `ST_SKIP` on a refused byte.

## Requirements
- R1: After reset the lock bits are 00, both arm latches are clear, `busy` is low and no strobe or acknowledge is active.
- R2: A data byte sent to device `1010010` with an address byte other than `FFh` is not acknowledged and changes no latch or lock bit.
- R3: The register byte `02h` sets the write-arm latch when its transaction stops, and does not raise `busy`.
- R4: The register byte `06h` sets both arm latches only when the write-arm latch is already set. The register-arm latch never becomes set while the write-arm latch is clear.
- R5: With both latches set, a register byte `000st010` (binary) raises `busy` in the cycle after the stop, for exactly `COMMIT_CYCLES` cycles. When `busy` falls, the lock bits become `st` (bit 4 to lock bit 1, bit 3 to lock bit 0) and the register-arm latch clears. The lock bits change at no other time.
- R6: With both latches set, a register byte `000st110` keeps the register-arm latch set, leaves the lock bits unchanged and does not raise `busy`.
- R7: The first data byte of a register write is acknowledged. A second data byte is refused, and at the stop the write is discarded with no change.
- R8: A register byte with any of bits 7, 6, 5 or 0 set is refused and changes nothing.
- R9: A memory write is refused (no acknowledge, no `mem_we`) when the lock bits protect its address: 01 protects C0h–FFh, 10 protects 80h–FFh, 11 protects all, 00 protects nothing. Allowed bytes strobe at the current address, which then advances by one.
- R10: A wiper write is acknowledged and strobed only when both lock bits are 0.
- R11: While `wp_pin` is high, no memory or wiper write is acknowledged or strobed.
- R12: While `busy` is high, every new transaction is ignored: no acknowledge and no strobe.
- R13: A register byte that matches no pattern, or that arrives without the latches a pattern needs, leaves both latches and the lock bits unchanged.
- R14: The stop of a transaction with at least one accepted memory or wiper byte raises `busy` for `COMMIT_CYCLES` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_pin | input | 1 | Hardware write protect, high blocks memory and wiper writes |
| start_evt | input | 1 | Start condition pulse |
| stop_evt | input | 1 | Stop condition pulse |
| dev_vld | input | 1 | Device-address byte valid pulse |
| dev_addr | input | 7 | Received device address |
| dev_rnw | input | 1 | Read/write bit of the device byte, 1 = read |
| addr_vld | input | 1 | Address byte valid pulse |
| addr_byte | input | ADDR_W | Received address byte |
| data_vld | input | 1 | Data byte valid pulse |
| data_byte | input | DATA_W | Received data byte |
| data_ack | output | 1 | Acknowledge for the byte of the previous cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| wpr_we | output | 1 | Wiper write strobe |
| wpr_sel | output | WSEL_W | Wiper index |
| wpr_wdata | output | DATA_W | Wiper position |
| busy | output | 1 | Nonvolatile commit in progress |
| wr_armed | output | 1 | Write-arm latch |
| reg_armed | output | 1 | Register-arm latch |
| lock_lvl | output | 2 | Stored lock bits |

## Verification
The hardest state to reach from the ports is a lock change. Each one needs three full register transactions in order, then a wait for the busy window to close. Every lock-dependent check therefore goes through a bench task that replays the arm, arm and commit sequence and then waits out `busy`. The bench uses this task to walk all four lock values and to test the address boundaries of each one. Ignoring commands while busy is checked by sending a memory write in the cycles right after a commit's stop, while the window is still open.

// File: rtl/wguard_pkg.sv
package wguard_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REG_ADDR,
        ST_REG_DATA,
        ST_REG_HOLD,
        ST_MEM_ADDR,
        ST_MEM_DATA,
        ST_WPR_ADDR,
        ST_WPR_DATA,
        ST_SKIP
    } ctl_state_t;

    localparam logic [6:0] DEV_MEM = 7'b1010000;
    localparam logic [6:0] DEV_WPR = 7'b1010001;
    localparam logic [6:0] DEV_CFG = 7'b1010010;

endpackage

// File: rtl/wguard_prot.sv
module wguard_prot #(
    parameter int ADDR_W = 8
) (
    input  logic [1:0]        lock_lvl,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wp_pin,
    output logic              mem_ok,
    output logic              wpr_ok
);
    logic in_quarter;
    logic in_half;
    logic guarded;

    assign in_quarter = (addr[ADDR_W-1:ADDR_W-2] == 2'b11);
    assign in_half    = addr[ADDR_W-1];

    always_comb begin
        unique case (lock_lvl)
            2'b00:   guarded = 1'b0;
            2'b01:   guarded = in_quarter;
            2'b10:   guarded = in_half;
            default: guarded = 1'b1;
        endcase
    end

    assign mem_ok = !wp_pin && !guarded;
    assign wpr_ok = !wp_pin && (lock_lvl == 2'b00);
endmodule

// File: rtl/wguard_timer.sv
module wguard_timer #(
    parameter int COMMIT_CYCLES = 625000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(COMMIT_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (go) begin
            cnt_q <= CW'(COMMIT_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));

    // R12: a commit is never started while one is still running
    assert_no_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy);
endmodule

// File: rtl/wguard_top.sv
module wguard_top
    import wguard_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 8,
    parameter int NUM_WPR       = 2,
    parameter int COMMIT_CYCLES = 625000,
    localparam int WSEL_W       = (NUM_WPR > 1) ? $clog2(NUM_WPR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_pin,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              dev_vld,
    input  logic [6:0]        dev_addr,
    input  logic              dev_rnw,
    input  logic              addr_vld,
    input  logic [ADDR_W-1:0] addr_byte,
    input  logic              data_vld,
    input  logic [DATA_W-1:0] data_byte,
    output logic              data_ack,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              wpr_we,
    output logic [WSEL_W-1:0] wpr_sel,
    output logic [DATA_W-1:0] wpr_wdata,
    output logic              busy,
    output logic              wr_armed,
    output logic              reg_armed,
    output logic [1:0]        lock_lvl
);
    localparam logic [ADDR_W-1:0] CFG_ADDR = '1;

    ctl_state_t state_q, state_n;

    logic [DATA_W-1:0] hold_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [WSEL_W-1:0] wsel_q;
    logic              dirty_q;
    logic              wr_arm_q, reg_arm_q;
    logic [1:0]        lock_q, pend_q;
    logic              pend_cfg_q;

    logic ack_n, mem_we_n, wpr_we_n;
    logic hold_ld, ptr_ld, ptr_inc, wsel_ld, dirty_set;
    logic cfg_apply, go, done, busy_w;
    logic mem_ok, wpr_ok;
    logic both_armed, pat_commit, pat_keep, bad_bits, wsel_bad;

    wguard_prot #(.ADDR_W(ADDR_W)) u_prot (
        .lock_lvl (lock_q),
        .addr     (ptr_q),
        .wp_pin   (wp_pin),
        .mem_ok   (mem_ok),
        .wpr_ok   (wpr_ok)
    );

    wguard_timer #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .busy  (busy_w),
        .done  (done)
    );

    assign both_armed = wr_arm_q && reg_arm_q;
    assign pat_commit = both_armed && (hold_q[7:5] == 3'b000) && (hold_q[2:0] == 3'b010);
    assign pat_keep   = both_armed && (hold_q[7:5] == 3'b000) && (hold_q[2:0] == 3'b110);
    assign bad_bits   = (data_byte[7:5] != 3'b000) || data_byte[0];
    assign wsel_bad   = (int'(addr_byte) >= NUM_WPR);

    // next-state and strobe decisions
    always_comb begin
        state_n   = state_q;
        ack_n     = 1'b0;
        mem_we_n  = 1'b0;
        wpr_we_n  = 1'b0;
        hold_ld   = 1'b0;
        ptr_ld    = 1'b0;
        ptr_inc   = 1'b0;
        wsel_ld   = 1'b0;
        dirty_set = 1'b0;
        cfg_apply = 1'b0;
        go        = 1'b0;
        if (stop_evt) begin
            state_n = ST_IDLE;
            if (state_q == ST_REG_HOLD) begin
                cfg_apply = 1'b1;
                go        = pat_commit && !busy_w;
            end else begin
                go = dirty_q && !busy_w;
            end
        end else if (start_evt) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (dev_vld) begin
                    if (busy_w || dev_rnw)     state_n = ST_SKIP;
                    else if (dev_addr == DEV_CFG) state_n = ST_REG_ADDR;
                    else if (dev_addr == DEV_MEM) state_n = ST_MEM_ADDR;
                    else if (dev_addr == DEV_WPR) state_n = ST_WPR_ADDR;
                    else                          state_n = ST_SKIP;
                end
                ST_REG_ADDR: if (addr_vld) begin
                    state_n = (addr_byte == CFG_ADDR) ? ST_REG_DATA : ST_SKIP;
                end
                ST_REG_DATA: if (data_vld) begin
                    if (bad_bits) begin
                        state_n = ST_SKIP;
                    end else begin
                        ack_n   = 1'b1;
                        hold_ld = 1'b1;
                        state_n = ST_REG_HOLD;
                    end
                end
                ST_REG_HOLD: if (data_vld) begin
                    state_n = ST_SKIP;
                end
                ST_MEM_ADDR: if (addr_vld) begin
                    ptr_ld  = 1'b1;
                    state_n = ST_MEM_DATA;
                end
                ST_MEM_DATA: if (data_vld) begin
                    if (mem_ok) begin
                        ack_n     = 1'b1;
                        mem_we_n  = 1'b1;
                        ptr_inc   = 1'b1;
                        dirty_set = 1'b1;
                    end else begin
                        state_n = ST_SKIP;
                    end
                end
                ST_WPR_ADDR: if (addr_vld) begin
                    wsel_ld = 1'b1;
                    state_n = wsel_bad ? ST_SKIP : ST_WPR_DATA;
                end
                ST_WPR_DATA: if (data_vld) begin
                    if (wpr_ok) begin
                        ack_n     = 1'b1;
                        wpr_we_n  = 1'b1;
                        dirty_set = 1'b1;
                    end else begin
                        state_n = ST_SKIP;
                    end
                end
                ST_SKIP: state_n = ST_SKIP;
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // datapath, latches and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q     <= '0;
            ptr_q      <= '0;
            wsel_q     <= '0;
            dirty_q    <= 1'b0;
            wr_arm_q   <= 1'b0;
            reg_arm_q  <= 1'b0;
            lock_q     <= 2'b00;
            pend_q     <= 2'b00;
            pend_cfg_q <= 1'b0;
            data_ack   <= 1'b0;
            mem_we     <= 1'b0;
            mem_addr   <= '0;
            mem_wdata  <= '0;
            wpr_we     <= 1'b0;
            wpr_sel    <= '0;
            wpr_wdata  <= '0;
        end else begin
            data_ack <= ack_n;
            mem_we   <= mem_we_n;
            wpr_we   <= wpr_we_n;
            if (mem_we_n) begin
                mem_addr  <= ptr_q;
                mem_wdata <= data_byte;
            end
            if (wpr_we_n) begin
                wpr_sel   <= wsel_q;
                wpr_wdata <= data_byte;
            end
            if (hold_ld) hold_q <= data_byte;
            if (ptr_ld)       ptr_q <= addr_byte;
            else if (ptr_inc) ptr_q <= ptr_q + 1'b1;
            if (wsel_ld) wsel_q <= addr_byte[WSEL_W-1:0];
            if (stop_evt)       dirty_q <= 1'b0;
            else if (dirty_set) dirty_q <= 1'b1;
            if (cfg_apply) begin
                if (pat_commit) begin
                    pend_q     <= hold_q[4:3];
                    pend_cfg_q <= 1'b1;
                end else if (pat_keep) begin
                    reg_arm_q <= 1'b1;
                end else if (hold_q == 8'h02) begin
                    wr_arm_q <= 1'b1;
                end else if (hold_q == 8'h06 && wr_arm_q) begin
                    wr_arm_q  <= 1'b1;
                    reg_arm_q <= 1'b1;
                end
            end
            if (done && pend_cfg_q) begin
                lock_q     <= pend_q;
                reg_arm_q  <= 1'b0;
                pend_cfg_q <= 1'b0;
            end
        end
    end

    assign busy      = busy_w;
    assign wr_armed  = wr_arm_q;
    assign reg_armed = reg_arm_q;
    assign lock_lvl  = lock_q;

    // R5: lock bits move only as the busy window closes
    assert_lock_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q != $past(lock_q)) |-> $fell(busy_w));
    // R4: register-arm latch rises only with write-arm set
    assert_reg_arm_needs_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_arm_q) |-> wr_arm_q);
    // R11: no memory strobe for a byte taken while the pin was high
    assert_mem_wp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !$past(wp_pin));
    // R10: wiper strobes only with lock bits clear
    assert_wpr_unlocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wpr_we |-> ($past(lock_q) == 2'b00));
    // R9: full lock never lets a memory strobe through
    assert_full_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(lock_q) != 2'b11));
    // R12: nothing is acknowledged during a commit
    assert_no_ack_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        data_ack |-> !$past(busy_w));
    // R9: at most one strobe per cycle
    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, wpr_we}));
endmodule

// File: tb/wguard_top_tb.sv
module wguard_top_tb;
    localparam int CYC = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wp_pin = 1'b0;
    logic       start_evt = 1'b0, stop_evt = 1'b0;
    logic       dev_vld = 1'b0, dev_rnw = 1'b0;
    logic [6:0] dev_addr = '0;
    logic       addr_vld = 1'b0, data_vld = 1'b0;
    logic [7:0] addr_byte = '0, data_byte = '0;
    logic       data_ack, mem_we, wpr_we, busy, wr_armed, reg_armed;
    logic [7:0] mem_addr, mem_wdata, wpr_wdata;
    logic [0:0] wpr_sel;
    logic [1:0] lock_lvl;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    wguard_top #(.COMMIT_CYCLES(CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .dev_vld(dev_vld), .dev_addr(dev_addr), .dev_rnw(dev_rnw),
        .addr_vld(addr_vld), .addr_byte(addr_byte),
        .data_vld(data_vld), .data_byte(data_byte),
        .data_ack(data_ack), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .wpr_we(wpr_we), .wpr_sel(wpr_sel),
        .wpr_wdata(wpr_wdata), .busy(busy), .wr_armed(wr_armed),
        .reg_armed(reg_armed), .lock_lvl(lock_lvl)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit guarded(input logic [1:0] lk, input logic [7:0] a);
        case (lk)
            2'b00:   return 1'b0;
            2'b01:   return a >= 8'hC0;
            2'b10:   return a >= 8'h80;
            default: return 1'b1;
        endcase
    endfunction

    task automatic do_start();
        start_evt = 1'b1; @(negedge clk); start_evt = 1'b0;
    endtask
    task automatic do_stop();
        stop_evt = 1'b1; @(negedge clk); stop_evt = 1'b0;
    endtask
    task automatic do_dev(input logic [6:0] d);
        dev_addr = d; dev_rnw = 1'b0; dev_vld = 1'b1; @(negedge clk); dev_vld = 1'b0;
    endtask
    task automatic do_addr(input logic [7:0] a);
        addr_byte = a; addr_vld = 1'b1; @(negedge clk); addr_vld = 1'b0;
    endtask
    task automatic do_data(input logic [7:0] d, output logic ack, output logic mwe,
                           output logic wwe, output logic [7:0] ma);
        data_byte = d; data_vld = 1'b1; @(negedge clk); data_vld = 1'b0;
        ack = data_ack; mwe = mem_we; wwe = wpr_we; ma = mem_addr;
    endtask

    task automatic wait_free();
        for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [7:0] b, output logic ack);
        logic m, w; logic [7:0] a;
        do_start(); do_dev(7'b1010010); do_addr(8'hFF);
        do_data(b, ack, m, w, a); do_stop();
    endtask

    task automatic set_lock(input logic [1:0] v);
        logic ack;
        cfg_write(8'h02, ack); cfg_write(8'h06, ack);
        cfg_write({3'b000, v, 3'b010}, ack); wait_free();
    endtask

    task automatic mem_try(input logic [7:0] a, input bit exp_ok, input string tag);
        logic ack, m, w; logic [7:0] ma;
        do_start(); do_dev(7'b1010000); do_addr(a);
        do_data(8'h5A, ack, m, w, ma);
        chk(ack == exp_ok, tag, ack, exp_ok);
        chk(m == exp_ok, tag, m, exp_ok);
        if (exp_ok) chk(ma == a, tag, ma, a);
        do_stop();
        chk(busy == exp_ok, {tag, " R14 busy"}, busy, exp_ok);
        wait_free();
    endtask

    task automatic wpr_try(input bit exp_ok, input string tag);
        logic ack, m, w; logic [7:0] ma;
        do_start(); do_dev(7'b1010001); do_addr(8'h01);
        do_data(8'h33, ack, m, w, ma);
        chk(ack == exp_ok, tag, ack, exp_ok);
        chk(w == exp_ok, tag, w, exp_ok);
        if (exp_ok) begin
            chk(wpr_sel == 1'b1, tag, wpr_sel, 1);
            chk(wpr_wdata == 8'h33, tag, wpr_wdata, 8'h33);
        end
        do_stop(); wait_free();
    endtask

    task automatic t_reset();
        chk(lock_lvl == 2'b00, "R1 lock", lock_lvl, 0);
        chk(!wr_armed && !reg_armed, "R1 latches", {wr_armed, reg_armed}, 0);
        chk(!busy && !data_ack && !mem_we && !wpr_we, "R1 idle", busy, 0);
    endtask

    task automatic t_wrong_addr();
        logic ack, m, w; logic [7:0] ma;
        do_start(); do_dev(7'b1010010); do_addr(8'h00);
        do_data(8'h02, ack, m, w, ma); do_stop();
        chk(ack == 1'b0, "R2 ack", ack, 0);
        chk(wr_armed == 1'b0, "R2 latch", wr_armed, 0);
    endtask

    task automatic t_no_latch();
        logic ack;
        cfg_write(8'h06, ack);
        chk(!wr_armed && !reg_armed, "R4 06h unarmed", {wr_armed, reg_armed}, 0);
        cfg_write(8'h12, ack);
        chk(!busy && lock_lvl == 2'b00, "R13 commit unarmed", lock_lvl, 0);
        cfg_write(8'h0C, ack);
        chk(!wr_armed && !reg_armed, "R13 odd byte", {wr_armed, reg_armed}, 0);
    endtask

    task automatic t_enable();
        logic ack;
        cfg_write(8'h02, ack);
        chk(ack && wr_armed && !reg_armed, "R3 arm", {ack, wr_armed, reg_armed}, 3'b110);
        chk(!busy, "R3 no busy", busy, 0);
        cfg_write(8'h06, ack);
        chk(wr_armed && reg_armed && !busy, "R4 arm both", {wr_armed, reg_armed, busy}, 3'b110);
    endtask

    task automatic t_commit();
        logic ack; int n;
        cfg_write(8'h12, ack);
        chk(busy && lock_lvl == 2'b00, "R5 lock held during busy", lock_lvl, 0);
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
        chk(n == CYC, "R5 busy length", n, CYC);
        chk(lock_lvl == 2'b10, "R5 lock stored", lock_lvl, 2);
        chk(!reg_armed && wr_armed, "R5 latch clear", {wr_armed, reg_armed}, 2'b10);
    endtask

    task automatic t_keep();
        logic ack;
        cfg_write(8'h06, ack);
        cfg_write(8'h1E, ack);
        chk(reg_armed && lock_lvl == 2'b10 && !busy, "R6 keep", {reg_armed, lock_lvl}, 3'b110);
    endtask

    task automatic t_reserved();
        logic ack;
        cfg_write(8'h92, ack);
        chk(!ack, "R8 bit7", ack, 0);
        cfg_write(8'h13, ack);
        chk(!ack, "R8 bit0", ack, 0);
        chk(!busy && lock_lvl == 2'b10 && reg_armed, "R8 unchanged", lock_lvl, 2);
    endtask

    task automatic t_two_bytes();
        logic a1, a2, m, w; logic [7:0] ma;
        do_start(); do_dev(7'b1010010); do_addr(8'hFF);
        do_data(8'h0A, a1, m, w, ma);
        do_data(8'h0A, a2, m, w, ma);
        do_stop();
        chk(a1 && !a2, "R7 acks", {a1, a2}, 2'b10);
        chk(!busy && lock_lvl == 2'b10, "R7 discarded", lock_lvl, 2);
    endtask

    task automatic t_busy_ignore();
        logic ack, m, w; logic [7:0] ma;
        cfg_write(8'h0A, ack);
        chk(busy, "R12 busy up", busy, 1);
        do_start(); do_dev(7'b1010000); do_addr(8'h00);
        do_data(8'h11, ack, m, w, ma); do_stop();
        chk(!ack && !m, "R12 ignored", {ack, m}, 0);
        wait_free();
        chk(lock_lvl == 2'b01, "R5 lock 01", lock_lvl, 1);
    endtask

    task automatic t_protect();
        logic [7:0] pts [6] = '{8'h00, 8'h7F, 8'h80, 8'hBF, 8'hC0, 8'hFF};
        for (int v = 0; v < 4; v++) begin
            set_lock(2'(v));
            chk(lock_lvl == 2'(v), "R9 lock set", lock_lvl, v);
            for (int k = 0; k < 6; k++)
                mem_try(pts[k], !guarded(2'(v), pts[k]), "R9 region");
        end
    endtask

    task automatic t_increment();
        logic a1, a2, m1, m2, w; logic [7:0] ma1, ma2;
        set_lock(2'b10);
        do_start(); do_dev(7'b1010000); do_addr(8'h7F);
        do_data(8'h01, a1, m1, w, ma1);
        do_data(8'h02, a2, m2, w, ma2);
        do_stop();
        chk(a1 && m1 && ma1 == 8'h7F, "R9 first byte", ma1, 8'h7F);
        chk(!a2 && !m2, "R9 stepped into guard", {a2, m2}, 0);
        chk(busy, "R14 busy after partial", busy, 1);
        wait_free();
    endtask

    task automatic t_wiper();
        wpr_try(1'b0, "R10 locked");
        set_lock(2'b00);
        wpr_try(1'b1, "R10 open");
    endtask

    task automatic t_wp();
        wp_pin = 1'b1;
        mem_try(8'h00, 1'b0, "R11 mem");
        wpr_try(1'b0, "R11 wiper");
        wp_pin = 1'b0;
        mem_try(8'h00, 1'b1, "R11 released");
    endtask

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog: actual timeout expected finish");
            end
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_wrong_addr();
                t_no_latch();
                t_enable();
                t_commit();
                t_keep();
                t_reserved();
                t_two_bytes();
                t_busy_ignore();
                t_protect();
                t_increment();
                t_wiper();
                t_wp();
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule